// File: doc/BRIEF.md
# Byte FIFO Pair with Pseudo-DMA Access Port

This block stores bytes in two independent queues: a 16-entry data queue and a 32-entry command queue. A processor reaches them through two ports. The register port moves one byte, reads the fill level of the data queue, or empties the data queue. The pseudo-DMA port lets software move one or two bytes per access. The block splits each two-byte access into two byte steps, most significant byte first.

A phase input decides which queue a write lands in, and which queue a pseudo-DMA read drains. Writes on the pseudo-DMA port are gated by a terminal-count input from an external transfer counter. The block pulses a decrement strobe for every byte it accepts. When each pseudo-DMA access completes it raises a service strobe. After a write the strobe always fires. After a read it fires only when the data queue has run low.

Both ports follow a valid/ready rule. A request is taken on a clock edge where its valid and ready are both high. Ready drops while a pseudo-DMA access is in flight. The pseudo-DMA port wins when both ports request in the same idle cycle. Read results come back with their own one-cycle valid pulse and cannot be stalled.

Top module: `byte_fifo_pdma`

## Requirements
- R1: A byte pushed into a full queue is dropped. `overrun` is high during that access, and the bytes already stored keep their values and order.
- R2: Popping an empty queue returns 0x00 and leaves its fill level at zero.
- R3: A register-port read with `rp_kind`=2 returns the data-queue fill level in bits 4:0, with bits 7:5 zero.
- R4: A register-port access with `rp_kind`=3 empties the data queue in one cycle and leaves the command queue untouched.
- R5: When `tc_zero` is high, a pseudo-DMA write byte step stores nothing. When it is low, the byte is stored and `tc_dec` pulses for one cycle.
- R6: A wide pseudo-DMA write stores bits 15:8 first and then bits 7:0. A wide read puts the first byte popped in bits 15:8. A narrow read returns its byte in bits 7:0 with bits 15:8 zero.
- R7: While `cmd_phase` is high, register writes (`rp_kind`=0) and pseudo-DMA reads and writes use the command queue. Register pops (`rp_kind`=1) always use the data queue.
- R8: When a pseudo-DMA read completes, `svc` pulses if the data queue then holds fewer than two bytes. Otherwise it stays low.
- R9: When a pseudo-DMA write completes, `svc` pulses whether or not any byte was stored.
- R10: `pd_ready` is high only while idle. A narrow access completes two cycles after the accepting edge and a wide access three cycles after it, with `pd_rvalid` high only for reads. `rp_ready` is low while `pd_valid` is high. Register read data appears with `rp_rvalid` in the cycle after acceptance.
- R11: Each queue returns bytes in the order written. The data queue holds 16 bytes and the command queue holds 32 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_phase | input | 1 | Routes writes and pseudo-DMA reads to the command queue |
| tc_zero | input | 1 | External transfer count has reached zero |
| tc_dec | output | 1 | Decrement strobe, one per accepted pseudo-DMA write byte |
| svc | output | 1 | Service strobe at pseudo-DMA completion |
| overrun | output | 1 | A push met a full queue |
| rp_valid | input | 1 | Register-port request |
| rp_ready | output | 1 | Register port can accept |
| rp_kind | input | 2 | 0 write, 1 pop data queue, 2 read fill level, 3 flush data queue |
| rp_wdata | input | 8 | Register write byte |
| rp_rvalid | output | 1 | Register read result valid |
| rp_rdata | output | 8 | Register read result |
| pd_valid | input | 1 | Pseudo-DMA request |
| pd_ready | output | 1 | Pseudo-DMA port idle |
| pd_write | input | 1 | 1 write, 0 read |
| pd_wide | input | 1 | 1 two-byte access, 0 one byte |
| pd_wdata | input | 16 | Pseudo-DMA write data |
| pd_rvalid | output | 1 | Pseudo-DMA read result valid |
| pd_rdata | output | 16 | Pseudo-DMA read result |

## Verification
The hardest case to reach is a wide write whose first byte consumes the last unit of the transfer count. In that case the second byte step must see `tc_zero` already raised and drop its byte. The bench loads its counter model with one and issues a wide write. The random phase also reloads the counter with small values, so wide writes often straddle zero. A full command queue is reached only by 32 writes in command phase, and the bench drives them directly before its random mix.

// File: rtl/byte_fifo_pdma_pkg.sv
package byte_fifo_pdma_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    RPK_PUSH  = 2'd0,
    RPK_POP   = 2'd1,
    RPK_FLAGS = 2'd2,
    RPK_FLUSH = 2'd3
  } rp_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FIRST = 2'd1,
    SQ_LAST  = 2'd2,
    SQ_DONE  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/pdq_byte_fifo.sv
module pdq_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          overrun
);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr, rptr_inc, wptr_inc;
  logic          empty, do_push, do_pop;

  generate
    if (POW2) begin : g_wrap_nat
      assign rptr_inc = rptr + AW'(1);
      assign wptr_inc = wptr + AW'(1);
    end else begin : g_wrap_cmp
      assign rptr_inc = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      assign wptr_inc = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
    end
  endgenerate

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop & ~empty & ~clr;
  assign do_push = push & (~full | do_pop) & ~clr;
  assign overrun = push & ~clr & ~do_push;
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr_inc;
      if (do_pop)  rptr <= rptr_inc;
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R1: a push into a full queue leaves the level unchanged
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));
  // R2: popping an empty queue keeps it empty
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (count == '0));
  // R4: clear leaves the queue empty
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R11: level never exceeds depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/pdq_sequencer.sv
module pdq_sequencer
  import byte_fifo_pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pd_valid,
  input  logic        pd_write,
  input  logic        pd_wide,
  input  logic [15:0] pd_wdata,
  output logic        pd_ready,
  output logic        pd_rvalid,
  output logic [15:0] pd_rdata,
  input  logic        tc_zero,
  input  logic        low_level,
  input  logic [7:0]  pop_byte,
  output logic        op_en,
  output logic        op_write,
  output logic [7:0]  op_byte,
  output logic        wr_step,
  output logic        tc_dec,
  output logic        svc
);
  sq_state_e   state;
  logic        lat_write, lat_wide;
  logic [15:0] lat_wdata, rbuf;
  logic        in_step, done;

  assign in_step   = (state == SQ_FIRST) || (state == SQ_LAST);
  assign done      = (state == SQ_DONE);
  assign op_write  = lat_write;
  assign op_byte   = (state == SQ_FIRST) ? lat_wdata[15:8] : lat_wdata[7:0];
  assign wr_step   = in_step & lat_write;
  assign op_en     = in_step & (~lat_write | ~tc_zero);
  assign tc_dec    = wr_step & ~tc_zero;
  assign pd_ready  = (state == SQ_IDLE);
  assign pd_rvalid = done & ~lat_write;
  assign svc       = done & (lat_write | low_level);
  assign pd_rdata  = rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      lat_write <= 1'b0;
      lat_wide  <= 1'b0;
      lat_wdata <= '0;
      rbuf      <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (pd_valid) begin
          lat_write <= pd_write;
          lat_wide  <= pd_wide;
          lat_wdata <= pd_wdata;
          rbuf      <= '0;
          state     <= pd_wide ? SQ_FIRST : SQ_LAST;
        end
        SQ_FIRST: begin
          if (!lat_write) rbuf[15:8] <= pop_byte;
          state <= SQ_LAST;
        end
        SQ_LAST: begin
          if (!lat_write) rbuf[7:0] <= pop_byte;
          state <= SQ_DONE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R10: acceptance drops ready for the access duration
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_ready) |=> !pd_ready);
  // R10: completion is followed by idle
  a_r10_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (svc || pd_rvalid) |=> pd_ready);
  // R6: a wide access takes two byte steps, high first
  a_r6_wide_two_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_valid && pd_ready && pd_wide) |=> (state == SQ_FIRST) ##1 (state == SQ_LAST));
  // R6: a narrow read leaves the upper half zero
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_rvalid && !lat_wide) |-> (pd_rdata[15:8] == 8'h00));
endmodule

// File: rtl/byte_fifo_pdma.sv
module byte_fifo_pdma
  import byte_fifo_pdma_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  localparam int D_CW = $clog2(DATA_DEPTH + 1),
  localparam int C_CW = $clog2(CMD_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_phase,
  input  logic        tc_zero,
  output logic        tc_dec,
  output logic        svc,
  output logic        overrun,
  input  logic        rp_valid,
  output logic        rp_ready,
  input  logic [1:0]  rp_kind,
  input  logic [7:0]  rp_wdata,
  output logic        rp_rvalid,
  output logic [7:0]  rp_rdata,
  input  logic        pd_valid,
  output logic        pd_ready,
  input  logic        pd_write,
  input  logic        pd_wide,
  input  logic [15:0] pd_wdata,
  output logic        pd_rvalid,
  output logic [15:0] pd_rdata
);
  logic            seq_op_en, seq_op_write, seq_wr_step;
  logic [7:0]      seq_op_byte, seq_pop_byte;
  logic            rp_acc, rp_wr, rp_rd, rp_fl, rp_flush;
  logic            wr_en, rd_seq;
  logic [7:0]      wr_byte;
  logic            d_push, d_pop, c_push, c_pop;
  logic [7:0]      d_head, c_head;
  logic [D_CW-1:0] d_count;
  logic [C_CW-1:0] c_count;
  logic            d_full, c_full, d_ovr, c_ovr;
  logic [7:0]      flags_val;

  assign rp_ready = pd_ready & ~pd_valid;
  assign rp_acc   = rp_valid & rp_ready;
  assign rp_wr    = rp_acc & (rp_kind == RPK_PUSH);
  assign rp_rd    = rp_acc & (rp_kind == RPK_POP);
  assign rp_fl    = rp_acc & (rp_kind == RPK_FLAGS);
  assign rp_flush = rp_acc & (rp_kind == RPK_FLUSH);

  assign wr_en   = (seq_op_en & seq_op_write) | rp_wr;
  assign wr_byte = seq_op_en ? seq_op_byte : rp_wdata;
  assign rd_seq  = seq_op_en & ~seq_op_write;
  assign d_push  = wr_en & ~cmd_phase;
  assign c_push  = wr_en & cmd_phase;
  assign d_pop   = rp_rd | (rd_seq & ~cmd_phase);
  assign c_pop   = rd_seq & cmd_phase;
  assign seq_pop_byte = cmd_phase ? c_head : d_head;
  assign overrun = d_ovr | c_ovr;

  always_comb begin
    flags_val = '0;
    flags_val[FLAG_W-1:0] = FLAG_W'(d_count);
  end

  pdq_byte_fifo #(.DEPTH(DATA_DEPTH), .W(8)) u_data_q (
    .clk(clk), .rst_n(rst_n), .clr(rp_flush),
    .push(d_push), .push_data(wr_byte), .pop(d_pop),
    .head(d_head), .count(d_count), .full(d_full), .overrun(d_ovr)
  );

  pdq_byte_fifo #(.DEPTH(CMD_DEPTH), .W(8)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .push(c_push), .push_data(wr_byte), .pop(c_pop),
    .head(c_head), .count(c_count), .full(c_full), .overrun(c_ovr)
  );

  pdq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .pd_valid(pd_valid), .pd_write(pd_write), .pd_wide(pd_wide),
    .pd_wdata(pd_wdata), .pd_ready(pd_ready), .pd_rvalid(pd_rvalid),
    .pd_rdata(pd_rdata), .tc_zero(tc_zero),
    .low_level(d_count < D_CW'(2)), .pop_byte(seq_pop_byte),
    .op_en(seq_op_en), .op_write(seq_op_write), .op_byte(seq_op_byte),
    .wr_step(seq_wr_step), .tc_dec(tc_dec), .svc(svc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_rvalid <= 1'b0;
      rp_rdata  <= '0;
    end else begin
      rp_rvalid <= rp_rd | rp_fl;
      if (rp_fl)      rp_rdata <= flags_val;
      else if (rp_rd) rp_rdata <= d_head;
    end
  end

  // R5: a write step at terminal count leaves both queues unchanged
  a_r5_no_push_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_wr_step && tc_zero) |=> ($stable(d_count) && $stable(c_count)));
  // R7: a command-phase byte write grows only the command queue
  a_r7_cmd_route: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_op_en && seq_op_write && cmd_phase && !c_full)
      |=> ((d_count == $past(d_count)) && (c_count == $past(c_count) + 1'b1)));
  // R1: a data-phase register write into a full data queue flags overrun
  a_r1_flag_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_wr && !cmd_phase && d_full) |-> overrun);
  // R10: register port blocked while pseudo-DMA requests
  a_r10_rp_yields: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |-> !rp_ready);
endmodule

// File: tb/byte_fifo_pdma_bench.sv
module byte_fifo_pdma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DQ_DEPTH = 16;
  localparam int CQ_DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_phase = 1'b0, tc_zero, tc_dec, svc, overrun;
  logic rp_valid = 1'b0, rp_ready, rp_rvalid;
  logic [1:0] rp_kind = 2'd0;
  logic [7:0] rp_wdata = 8'd0, rp_rdata;
  logic pd_valid = 1'b0, pd_ready, pd_write = 1'b0, pd_wide = 1'b0, pd_rvalid;
  logic [15:0] pd_wdata = 16'd0, pd_rdata;

  logic [7:0] tc;
  logic       tc_ld = 1'b0;
  logic [7:0] tc_val = 8'd0;
  int checks = 0, fails = 0, exp_tc = 0;
  logic [7:0] dq[$];
  logic [7:0] cq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tc_zero = (tc == 8'd0);
  always @(posedge clk) begin
    if (tc_ld) tc <= tc_val;
    else if (tc_dec && tc != 8'd0) tc <= tc - 8'd1;
  end

  byte_fifo_pdma u_byte_fifo_pdma (
    .clk(clk), .rst_n(rst_n), .cmd_phase(cmd_phase), .tc_zero(tc_zero),
    .tc_dec(tc_dec), .svc(svc), .overrun(overrun),
    .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_kind(rp_kind),
    .rp_wdata(rp_wdata), .rp_rvalid(rp_rvalid), .rp_rdata(rp_rdata),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_write(pd_write),
    .pd_wide(pd_wide), .pd_wdata(pd_wdata), .pd_rvalid(pd_rvalid),
    .pd_rdata(pd_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_push(input bit c, input logic [7:0] b);
    if (c) begin
      if (cq.size() < CQ_DEPTH) begin cq.push_back(b); return 0; end
    end else begin
      if (dq.size() < DQ_DEPTH) begin dq.push_back(b); return 0; end
    end
    return 1;
  endfunction

  function automatic logic [7:0] m_pop(input bit c);
    if (c) return (cq.size() == 0) ? 8'h00 : cq.pop_front();
    return (dq.size() == 0) ? 8'h00 : dq.pop_front();
  endfunction

  task automatic load_tc(input int v);
    @(negedge clk); tc_val = 8'(v); tc_ld = 1'b1;
    @(negedge clk); tc_ld = 1'b0; exp_tc = v;
  endtask

  // register op; returns read data and overrun seen during the access
  task automatic rp_op(input bit cp, input int kind, input logic [7:0] wd,
                       output logic [7:0] rd, output bit ovr);
    @(negedge clk);
    cmd_phase = cp; rp_kind = 2'(kind); rp_wdata = wd; rp_valid = 1'b1;
    #1 ovr = overrun;
    @(posedge clk);
    @(negedge clk);
    rp_valid = 1'b0;
    rd = rp_rdata;
    if (kind == 1 || kind == 2) chk("R10 rp_rvalid", int'(rp_rvalid), 1);
  endtask

  task automatic reg_write(input bit cp, input logic [7:0] b, input string req);
    logic [7:0] rd; bit ovr; int e;
    e = m_push(cp, b);
    rp_op(cp, 0, b, rd, ovr);
    chk(req, int'(ovr), e);
  endtask

  task automatic reg_pop(input string req);
    logic [7:0] rd; bit ovr; logic [7:0] e;
    e = m_pop(1'b0);
    rp_op(1'b0, 1, 8'h00, rd, ovr);
    chk(req, int'(rd), int'(e));
  endtask

  task automatic reg_flags(input string req);
    logic [7:0] rd; bit ovr;
    rp_op(cmd_phase, 2, 8'h00, rd, ovr);
    chk(req, int'(rd), dq.size());
  endtask

  task automatic reg_flush();
    logic [7:0] rd; bit ovr;
    dq.delete();
    rp_op(cmd_phase, 3, 8'h00, rd, ovr);
  endtask

  task automatic pd_op(input bit cp, input bit wr, input bit wide, input logic [15:0] wd);
    logic [15:0] e_rd;
    e_rd = 16'h0000;
    if (wr) begin
      if (wide) begin
        if (exp_tc > 0) begin void'(m_push(cp, wd[15:8])); exp_tc--; end
      end
      if (exp_tc > 0) begin void'(m_push(cp, wd[7:0])); exp_tc--; end
    end else begin
      if (wide) begin e_rd[15:8] = m_pop(cp); e_rd[7:0] = m_pop(cp); end
      else e_rd[7:0] = m_pop(cp);
    end
    @(negedge clk);
    chk("R10 pd_ready idle", int'(pd_ready), 1);
    cmd_phase = cp; pd_write = wr; pd_wide = wide; pd_wdata = wd; pd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pd_valid = 1'b0;
    chk("R10 busy", int'(pd_ready), 0);
    repeat (wide ? 2 : 1) @(negedge clk);
    if (wr) begin
      chk("R9 svc on write", int'(svc), 1);
      chk("R10 no rvalid on write", int'(pd_rvalid), 0);
      chk("R5 tc count", int'(tc), exp_tc);
    end else begin
      chk("R10 rvalid", int'(pd_rvalid), 1);
      chk("R6 read data", int'(pd_rdata), int'(e_rd));
      chk("R8 svc low level", int'(svc), (dq.size() < 2) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd; bit ovr;
    void'($urandom(32'h1b5e_ed01));
    tc_val = 8'd0; tc_ld = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; tc_ld = 1'b0;
    @(negedge clk);
    chk("R10 reset pd_ready", int'(pd_ready), 1);
    chk("R10 reset rp_ready", int'(rp_ready), 1);
    chk("R9 reset svc", int'(svc), 0);
    chk("R10 reset pd_rvalid", int'(pd_rvalid), 0);
    reg_flags("R3 reset level");

    // R2: empty pop
    reg_pop("R2 empty pop");
    reg_flags("R2 level after empty pop");

    // R1 / R11: fill data queue then overflow
    for (int i = 0; i < DQ_DEPTH; i++) reg_write(1'b0, 8'(8'h10 + i), "R1 no overrun");
    reg_flags("R3 full level");
    reg_write(1'b0, 8'hEE, "R1 overrun flag");
    reg_flags("R1 level after overrun");
    for (int i = 0; i < DQ_DEPTH; i++) reg_pop("R11 data order");

    // R5: gated writes
    load_tc(0);
    pd_op(1'b0, 1'b1, 1'b0, 16'h0042);
    reg_flags("R5 ignored at zero");
    load_tc(1);
    pd_op(1'b0, 1'b1, 1'b1, 16'hABCD);
    reg_flags("R5 one byte then stop");
    reg_pop("R5 high byte kept");

    // R6: byte order
    load_tc(2);
    pd_op(1'b0, 1'b1, 1'b1, 16'h1234);
    reg_pop("R6 first stored high");
    reg_pop("R6 second stored low");
    reg_write(1'b0, 8'h55, "R6 setup");
    reg_write(1'b0, 8'h66, "R6 setup");
    pd_op(1'b0, 1'b0, 1'b1, 16'h0000);
    // R8: svc stays low when two or more remain
    for (int i = 0; i < 3; i++) reg_write(1'b0, 8'(8'hA0 + i), "R8 setup");
    pd_op(1'b0, 1'b0, 1'b0, 16'h0000);
    pd_op(1'b0, 1'b0, 1'b0, 16'h0000);

    // R7: routing
    reg_write(1'b1, 8'h77, "R7 cmd write");
    reg_flags("R7 data level unchanged");
    reg_pop("R7 reg pop uses data queue");
    pd_op(1'b1, 1'b0, 1'b0, 16'h0000);

    // R4: flush affects data queue only
    reg_write(1'b1, 8'h99, "R4 setup");
    reg_write(1'b0, 8'h11, "R4 setup");
    reg_write(1'b0, 8'h22, "R4 setup");
    reg_flush();
    reg_flags("R4 flushed level");
    pd_op(1'b1, 1'b0, 1'b0, 16'h0000);

    // R11: command queue depth
    for (int i = 0; i < CQ_DEPTH + 1; i++) reg_write(1'b1, 8'(i * 3), "R11 cmd depth overrun");
    for (int i = 0; i < CQ_DEPTH / 2; i++) pd_op(1'b1, 1'b0, 1'b1, 16'h0000);
    pd_op(1'b1, 1'b0, 1'b0, 16'h0000);

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit cp;
      int k;
      cp = ($urandom % 4) == 0;
      k = $urandom % 9;
      if (exp_tc == 0 && ($urandom % 3) == 0) load_tc($urandom % 5);
      case (k)
        0, 1: reg_write(cp, 8'($urandom), "R11 random write");
        2:    reg_pop("R11 random pop");
        3:    reg_flags("R3 random level");
        4:    if (($urandom % 4) == 0) reg_flush(); else reg_flags("R3 random level");
        5:    pd_op(cp, 1'b1, 1'b0, 16'($urandom));
        6:    pd_op(cp, 1'b1, 1'b1, 16'($urandom));
        default: pd_op(cp, 1'b0, 1'($urandom), 16'h0000);
      endcase
    end
    reg_flags("R3 final level");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule